// File: doc/BRIEF.md
# Delay Search Controller

This controller finds the length of an unknown delay by comparing it against a programmable delay. The device under test is driven from a reference path that stays at its shortest setting. A second path, set by a digital code, makes the sampling clock of a capture flip-flop that watches the device output. For each trial the controller raises one launch strobe, which triggers both paths together. It waits a set number of cycles and then reads the captured bit. A captured 1 means the programmed delay is longer than the unknown delay. A captured 0 means it is shorter.

A measurement starts with a start pulse. The controller runs a binary search over the code from the most significant bit down to the least significant bit. Every decision is a majority vote over several trials, so an odd metastable sample does not change the result. After the search it checks the final code and the code one above it, to confirm where the captured bit changes from 0 to 1. The result is the first code at which the captured bit is 1, which is the unknown delay in code steps. A one-cycle done pulse marks the result as valid. A flag is raised when no 0-to-1 change can be confirmed inside the code range.

Top module: `delay_search`

## Requirements
- R1: After reset, launch, done and noEdge are low, and delayCode and measCode are zero.
- R2: A start seen while idle begins a measurement. Launch is high in the cycle after that edge, and delayCode holds only its top bit set (512 for a 10-bit code).
- R3: Each trial has one cycle with launch high, followed by SETTLE cycles with launch low. delayCode does not change during a trial. sampleBit is captured at the clock edge that ends the last of those low cycles, and the next trial's launch cycle comes straight after.
- R4: Each decision takes VOTES trials at the same code and uses the majority value of the captured bits. A minority of flipped samples does not change the decision.
- R5: The search tests the code bits from the most significant to the least significant. A majority 1 (delay too long) clears the bit under test. A majority 0 (delay too short) keeps it. After the last bit, one group of trials runs at the accumulated code and then one at that code plus one.
- R6: When the accumulated code gives a majority 0 and the code above it gives a majority 1, measCode is set to that upper code and noEdge is 0. Thresholds 1 and 1023 are valid results.
- R7: When the captured bit stays 0 up to the all-ones code, measCode is the all-ones code and noEdge is 1, with no trial at a higher code.
- R8: When the captured bit is 1 even at code 0, measCode is 0 and noEdge is 1, with no trial at code 1.
- R9: done is high for exactly one cycle, in the cycle after the final decision, with launch low and measCode and noEdge valid. Both outputs hold their values until the next result.
- R10: A start that arrives while a measurement is running has no effect on the trial sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| sampleBit | input | 1 | Captured flip-flop value: 1 = programmed delay too long |
| launch | output | 1 | One-cycle trigger for both delay paths |
| delayCode | output | CODE_W | Code for the programmable delay path |
| measCode | output | CODE_W | Measured edge code |
| noEdge | output | 1 | No confirmed 0-to-1 change inside the code range |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with a 10-bit code, three votes per decision and a settle count of three. This keeps a full measurement under 150 cycles, so every boundary threshold can be run to completion: 0, 1, an interior value, 1023 and one above the range. With three votes, the bench can invert the first trial of every group and show that the majority still gives the right decision. The short trial also makes room to send a stray start in the middle of a run.

// File: rtl/delay_search_pkg.sv
package delay_search_pkg;

  typedef enum logic [1:0] {
    PH_SAR = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2
  } phase_e;

  typedef struct packed {
    logic   init;
    logic   sampleEn;
    logic   decide;
    phase_e phase;
  } dpStrobe_t;

  typedef struct packed {
    logic vote;
    logic accMax;
  } dpStatus_t;

endpackage

// File: rtl/delay_search_dp.sv
module delay_search_dp
  import delay_search_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int VOTES  = 3,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic              sampleBit,
  output dpStatus_t         status,
  output logic [CODE_W-1:0] delayCode,
  output logic [CODE_W-1:0] measCode,
  output logic              noEdge,
  output logic              done
);

  localparam int VOTE_W = $clog2(VOTES + 1);
  localparam int MAJ    = VOTES / 2;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] acc, codeQ, measQ, accNext, stepMask;
  logic [VOTE_W-1:0] ones;
  logic              edgeMissQ, doneQ;
  logic              vote;

  // majority includes the sample being captured at this edge
  always_comb begin
    vote     = (int'(ones) + int'(sampleBit)) > MAJ;
    accNext  = vote ? acc : codeQ;
    stepMask = (bitIdx == '0) ? '0 : (CODE_W'(1) << (bitIdx - BIT_W'(1)));
  end

  assign status.vote   = vote;
  assign status.accMax = &acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      codeQ     <= '0;
      measQ     <= '0;
      ones      <= '0;
      edgeMissQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strb.init) begin
        acc   <= '0;
        codeQ <= TOP_CODE;
        ones  <= '0;
      end else if (strb.decide) begin
        ones <= '0;
        unique case (strb.phase)
          PH_SAR: begin
            acc   <= accNext;
            codeQ <= accNext | stepMask;
          end
          PH_LO: begin
            if (vote || (&acc)) begin
              measQ     <= acc;
              edgeMissQ <= 1'b1;
              doneQ     <= 1'b1;
            end else begin
              codeQ <= acc + CODE_W'(1);
            end
          end
          default: begin
            measQ     <= codeQ;
            edgeMissQ <= !vote;
            doneQ     <= 1'b1;
          end
        endcase
      end else if (strb.sampleEn) begin
        ones <= ones + VOTE_W'(sampleBit);
      end
    end
  end

  assign delayCode = codeQ;
  assign measCode  = measQ;
  assign noEdge    = edgeMissQ;
  assign done      = doneQ;

  // R5: the accumulated code never falls during the bit search
  a_r5_acc_rises: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && strb.phase == PH_SAR) |=> acc >= $past(acc));

  // R4: vote counter is cleared after every decision
  a_r4_votes_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |=> ones == '0);

endmodule

// File: rtl/delay_search_ctrl.sv
module delay_search_ctrl
  import delay_search_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SETTLE = 4,
  parameter int VOTES  = 3,
  parameter int BIT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  dpStatus_t        status,
  output dpStrobe_t        strb,
  output logic [BIT_W-1:0] bitIdx,
  output logic             launch
);

  localparam int WAIT_W = $clog2(SETTLE + 1);
  localparam int VCNT_W = $clog2(VOTES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE - 1);
  localparam logic [VCNT_W-1:0] VOTE_LAST = VCNT_W'(VOTES - 1);
  localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(CODE_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRE, ST_WAIT} state_e;

  state_e            state;
  phase_e            phase;
  logic [BIT_W-1:0]  bitQ;
  logic [WAIT_W-1:0] waitCnt;
  logic [VCNT_W-1:0] voteCnt;
  logic              sampleEdge, groupEnd, loFinish;

  always_comb begin
    sampleEdge    = (state == ST_WAIT) && (waitCnt == WAIT_LAST);
    groupEnd      = sampleEdge && (voteCnt == VOTE_LAST);
    loFinish      = status.vote || status.accMax;
    strb.init     = (state == ST_IDLE) && start;
    strb.sampleEn = sampleEdge;
    strb.decide   = groupEnd;
    strb.phase    = phase;
    launch        = (state == ST_FIRE);
  end

  assign bitIdx = bitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_SAR;
      bitQ    <= '0;
      waitCnt <= '0;
      voteCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_FIRE;
            phase   <= PH_SAR;
            bitQ    <= BIT_TOP;
            voteCnt <= '0;
          end
        end
        ST_FIRE: begin
          state   <= ST_WAIT;
          waitCnt <= '0;
        end
        default: begin
          if (waitCnt != WAIT_LAST) begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end else if (voteCnt != VOTE_LAST) begin
            voteCnt <= voteCnt + VCNT_W'(1);
            state   <= ST_FIRE;
          end else begin
            voteCnt <= '0;
            unique case (phase)
              PH_SAR: begin
                state <= ST_FIRE;
                if (bitQ == '0) phase <= PH_LO;
                else            bitQ  <= bitQ - BIT_W'(1);
              end
              PH_LO: begin
                if (loFinish) begin
                  state <= ST_IDLE;
                end else begin
                  phase <= PH_HI;
                  state <= ST_FIRE;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R2: an idle start leads to a launch in the next cycle
  a_r2_start_fires: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> launch);

  // R3: launch lasts a single cycle
  a_r3_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);

  // R10: start during a launch cycle does not restart the sequence
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (launch && start) |=> (state == ST_WAIT && waitCnt == '0));

endmodule

// File: rtl/delay_search.sv
module delay_search
  import delay_search_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SETTLE = 4,
  parameter int VOTES  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sampleBit,
  output logic              launch,
  output logic [CODE_W-1:0] delayCode,
  output logic [CODE_W-1:0] measCode,
  output logic              noEdge,
  output logic              done
);

  localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  dpStrobe_t        strb;
  dpStatus_t        status;
  logic [BIT_W-1:0] bitIdx;

  delay_search_ctrl #(
    .CODE_W(CODE_W), .SETTLE(SETTLE), .VOTES(VOTES), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strb   (strb),
    .bitIdx (bitIdx),
    .launch (launch)
  );

  delay_search_dp #(
    .CODE_W(CODE_W), .VOTES(VOTES), .BIT_W(BIT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .sampleBit (sampleBit),
    .status    (status),
    .delayCode (delayCode),
    .measCode  (measCode),
    .noEdge    (noEdge),
    .done      (done)
  );

  // R3: code stays put in the cycle after a launch
  a_r3_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> $stable(delayCode));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no trial is launched alongside done
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !launch);

  // R6: a confirmed edge is never at code zero
  a_r6_edge_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noEdge) |-> measCode != '0);

endmodule

// File: tb/delay_search_tb.sv
module delay_search_tb;

  localparam int CODE_W = 10;
  localparam int SETTLE = 3;
  localparam int VOTES  = 3;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic flip = 1'b0;
  int   thr = 0;
  logic sampleBit, launch, noEdge, done;
  logic [CODE_W-1:0] delayCode, measCode;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  // device model: captured 1 when the programmed delay reaches the threshold
  assign sampleBit = ((int'(delayCode) >= thr) ? 1'b1 : 1'b0) ^ flip;

  delay_search #(.CODE_W(CODE_W), .SETTLE(SETTLE), .VOTES(VOTES)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sampleBit(sampleBit),
    .launch(launch), .delayCode(delayCode), .measCode(measCode),
    .noEdge(noEdge), .done(done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock of the reference model, compared away from the edge
  task automatic step(bit eLaunch, int eCode, bit eDone, string req);
    @(negedge clk);
    flip  = 1'b0;
    start = 1'b0;
    chk(launch == eLaunch, req, "launch", int'(launch), int'(eLaunch));
    chk(int'(delayCode) == eCode, req, "delayCode", int'(delayCode), eCode);
    chk(done == eDone, req, "done", int'(done), int'(eDone));
  endtask

  task automatic group(int code, bit noisy, bit poke, string req, output bit vote);
    for (int t = 0; t < VOTES; t++) begin
      step(1'b1, code, 1'b0, req);
      if (poke && t == 0) start = 1'b1;
      for (int s = 0; s < SETTLE; s++) begin
        step(1'b0, code, 1'b0, req);
        if (poke && t == 1 && s == 0) start = 1'b1;
        if (noisy && t == 0 && s == SETTLE - 1) flip = 1'b1;
      end
    end
    vote = (code >= thr);
  endtask

  task automatic runMeas(int th, bit noisy, bit poke, string req);
    int  acc, lastCode, expM;
    bit  v, lo, hi, expN;
    thr = th;
    @(negedge clk);
    start = 1'b1;
    acc = 0;
    for (int b = CODE_W - 1; b >= 0; b--) begin
      group(acc | (1 << b), noisy, poke && b == CODE_W - 2, "R3", v);
      if (!v) acc = acc | (1 << b);
    end
    group(acc, noisy, 1'b0, "R5", lo);
    if (lo || acc == MAXC) begin
      expM = acc; expN = 1'b1; lastCode = acc;
    end else begin
      group(acc + 1, noisy, 1'b0, "R5", hi);
      expM = acc + 1; expN = !hi; lastCode = acc + 1;
    end
    step(1'b0, lastCode, 1'b1, "R9");
    chk(int'(measCode) == expM, req, "measCode", int'(measCode), expM);
    chk(noEdge == expN, req, "noEdge", int'(noEdge), int'(expN));
    step(1'b0, lastCode, 1'b0, "R9");
    chk(int'(measCode) == expM, "R9", "measCode held", int'(measCode), expM);
    chk(noEdge == expN, "R9", "noEdge held", int'(noEdge), int'(expN));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(launch == 1'b0, "R1", "launch", int'(launch), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(noEdge == 1'b0, "R1", "noEdge", int'(noEdge), 0);
    chk(delayCode == '0, "R1", "delayCode", int'(delayCode), 0);
    chk(measCode == '0, "R1", "measCode", int'(measCode), 0);
    rstN = 1'b1;
    step(1'b0, 0, 1'b0, "R1");

    runMeas(357, 1'b0, 1'b0, "R6");   // interior edge, R2 first code checked in step
    runMeas(357, 1'b1, 1'b0, "R4");   // one flipped sample per group
    runMeas(1, 1'b0, 1'b0, "R6");     // lowest confirmable edge
    runMeas(MAXC, 1'b0, 1'b0, "R6");  // highest confirmable edge
    runMeas(0, 1'b0, 1'b0, "R8");     // too long even at code 0
    runMeas(MAXC + 1, 1'b0, 1'b0, "R7"); // never too long
    runMeas(600, 1'b0, 1'b1, "R10");  // stray start while busy
    runMeas(77, 1'b1, 1'b0, "R5");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule